// File: doc/BRIEF.md
# Gated Event Totalizer with Zero Output

This block is a 16-bit down counter that reloads itself. It counts either pulses from outside the chip or ticks from an internal timebase. In external mode it counts rising edges of an asynchronous pulse input, but only while an asynchronous, active-high enable level is high. In internal mode it counts ticks of a prescaled timebase, and the enable level plays no part. The timebase runs at one of two rates, and the slow rate is one hundredth of the fast rate.

When an event brings the count to zero, the zero flag output goes high. The flag stays high until the next event, which reloads the count from the load-value input. A host uses a small command port. One command copies the load value into the counter. Another command copies the readable count into a snapshot output. In external mode the readable count is refreshed only on every fourth counted event. Software therefore sees the count move in steps of four while pulses are being totalized.

Top module: `event_totalizer`

## Requirements
- R1: A command cycle with code 0x82 copies `load_val_i` into the count and into the readable register, and clears the zero flag and the event phase. Code 0x84 copies the readable register to `snap_o` on the next clock edge. All other codes leave every output unchanged.
- R2: The event that brings a nonzero count to zero raises `zero_o`, and `zero_o` stays high for as long as no further event arrives.
- R3: The first event that arrives while the count is zero reloads `load_val_i` and drops `zero_o`.
- R4: In external mode (`src_int_i` = 0), each rising edge of `ext_evt_i` decrements the count by one. The edge passes through a two-flop synchronizer before detection.
- R5: In external mode, while `ext_gate_i` is low, edges on `ext_evt_i` change neither the count nor the event phase.
- R6: In external mode, the readable register takes the new count only on every fourth counted event after a load. Between those events it holds its value.
- R7: In internal mode (`src_int_i` = 1), the count decrements once every FAST_DIV clocks when `slow_tb_i` = 0, and once every FAST_DIV*SLOW_RATIO clocks when `slow_tb_i` = 1. `ext_gate_i` has no effect in this mode.
- R8: In internal mode, the readable register follows the count on every tick.
- R9: After reset, `zero_o` is 0, `snap_o` is 0, and the count and readable register are 0.
- R10: Changing `src_int_i` leaves the count unchanged, and counting continues from that value in the new mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_evt_i | input | 1 | Asynchronous external pulse input |
| ext_gate_i | input | 1 | Asynchronous enable level for external counting |
| src_int_i | input | 1 | 0 = external pulses, 1 = internal timebase |
| slow_tb_i | input | 1 | Internal timebase rate: 0 = fast, 1 = slow |
| cmd_valid_i | input | 1 | Command strobe, one cycle |
| cmd_code_i | input | 8 | Command code (0x82 load, 0x84 latch) |
| load_val_i | input | 16 | Reload and preload value |
| zero_o | output | 1 | High while the count rests at zero |
| snap_o | output | 16 | Latched copy of the readable register |

## Verification
The checker runs on every cycle. It checks the single-step decrement, the reload when an event arrives at zero, that the zero flag holds between events, that a low enable freezes the count in external mode, the effect of the load and latch commands, and that the readable register tracks the count in internal mode. Other behaviours can only be seen across several events, so the bench scenarios show them. These are the refresh every fourth event, the exact tick rates of the two timebase settings, the immunity of internal mode to the enable level, and the preservation of the count when the mode changes. The bench observes all of these through latched snapshots.

// File: rtl/totalizer_pkg.sv
package totalizer_pkg;
    localparam int CNT_W       = 16;
    localparam int REFRESH_DIV = 4;
    localparam int PH_W        = $clog2(REFRESH_DIV);

    localparam logic [7:0] CMD_LOAD  = 8'h82;
    localparam logic [7:0] CMD_LATCH = 8'h84;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t            cnt;
        cnt_t            rd;
        cnt_t            snap;
        logic [PH_W-1:0] phase;
        logic            zero;
        logic            int_mode;
        logic            evt_prev;
    } core_t;
endpackage

// File: rtl/level_sync.sv
module level_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign level_o = sh_q[STAGES-1];
endmodule

// File: rtl/tick_gen.sv
module tick_gen #(
    parameter int FAST_DIV   = 4,
    parameter int SLOW_RATIO = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_i,
    output logic tick_o
);
    localparam int PW = (FAST_DIV > 2) ? $clog2(FAST_DIV) : 1;
    localparam int SW = (SLOW_RATIO > 2) ? $clog2(SLOW_RATIO) : 1;

    logic [PW-1:0] pre_d, pre_q;
    logic [SW-1:0] sl_d, sl_q;
    logic          fast_tick, slow_tick;

    always_comb begin
        fast_tick = (pre_q == PW'(FAST_DIV - 1));
        slow_tick = fast_tick && (sl_q == SW'(SLOW_RATIO - 1));
        pre_d     = fast_tick ? '0 : pre_q + 1'b1;
        sl_d      = sl_q;
        if (fast_tick) sl_d = slow_tick ? '0 : sl_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            sl_q  <= '0;
        end else begin
            pre_q <= pre_d;
            sl_q  <= sl_d;
        end
    end

    assign tick_o = slow_i ? slow_tick : fast_tick;
endmodule

// File: rtl/event_totalizer.sv
module event_totalizer #(
    parameter int SYNC_STAGES = 2,
    parameter int FAST_DIV    = 4,
    parameter int SLOW_RATIO  = 100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ext_evt_i,
    input  logic        ext_gate_i,
    input  logic        src_int_i,
    input  logic        slow_tb_i,
    input  logic        cmd_valid_i,
    input  logic [7:0]  cmd_code_i,
    input  logic [15:0] load_val_i,
    output logic        zero_o,
    output logic [15:0] snap_o
);
    import totalizer_pkg::*;

    logic  evt_lvl, gate_lvl, tick, evt, do_load, do_latch;
    core_t c_d, c_q;

    level_sync #(.STAGES(SYNC_STAGES)) u_evt_sync (
        .clk(clk), .rst_n(rst_n), .async_i(ext_evt_i), .level_o(evt_lvl)
    );

    level_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
        .clk(clk), .rst_n(rst_n), .async_i(ext_gate_i), .level_o(gate_lvl)
    );

    tick_gen #(.FAST_DIV(FAST_DIV), .SLOW_RATIO(SLOW_RATIO)) u_tick (
        .clk(clk), .rst_n(rst_n), .slow_i(slow_tb_i), .tick_o(tick)
    );

    always_comb begin
        cnt_t nxt;
        do_load  = cmd_valid_i && (cmd_code_i == CMD_LOAD);
        do_latch = cmd_valid_i && (cmd_code_i == CMD_LATCH);
        evt      = c_q.int_mode ? tick : (evt_lvl && !c_q.evt_prev && gate_lvl);

        c_d          = c_q;
        c_d.evt_prev = evt_lvl;
        c_d.int_mode = src_int_i;
        nxt          = c_q.cnt;

        if (do_load) begin
            c_d.cnt   = load_val_i;
            c_d.rd    = load_val_i;
            c_d.phase = '0;
            c_d.zero  = 1'b0;
        end else if (evt) begin
            if (c_q.cnt == '0) begin
                nxt      = load_val_i;
                c_d.zero = 1'b0;
            end else begin
                nxt      = c_q.cnt - 1'b1;
                c_d.zero = (nxt == '0);
            end
            c_d.cnt = nxt;
            if (c_q.int_mode) begin
                c_d.rd = nxt;
            end else begin
                c_d.phase = c_q.phase + 1'b1;
                if (c_q.phase == PH_W'(REFRESH_DIV - 1)) c_d.rd = nxt;
            end
        end

        if (do_latch) c_d.snap = c_q.rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign zero_o = c_q.zero;
    assign snap_o = c_q.snap;
endmodule

// File: rtl/event_totalizer_chk.sv
module event_totalizer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        evt,
    input logic        gate_lvl,
    input logic        do_load,
    input logic        do_latch,
    input logic        int_mode,
    input logic [15:0] cnt,
    input logic [15:0] rd,
    input logic [15:0] load_val,
    input logic        zero,
    input logic [15:0] snap
);
    // R1
    load_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_load |=> (cnt == $past(load_val)) && (rd == $past(load_val)) && !zero);

    // R1
    latch_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_latch |=> (snap == $past(rd)));

    // R2
    zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && !evt && !do_load) |=> zero);

    // R2
    zero_means_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero |-> (cnt == 16'd0));

    // R3
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && cnt == 16'd0 && !do_load) |=> (cnt == $past(load_val)) && !zero);

    // R4
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && cnt != 16'd0 && !do_load) |=> (cnt == $past(cnt) - 16'd1));

    // R5
    gate_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_mode && !gate_lvl && !do_load) |=> $stable(cnt));

    // R8
    int_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_mode && evt && !do_load) |=> (rd == cnt));
endmodule

bind event_totalizer event_totalizer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .evt(evt), .gate_lvl(gate_lvl),
    .do_load(do_load), .do_latch(do_latch), .int_mode(c_q.int_mode),
    .cnt(c_q.cnt), .rd(c_q.rd), .load_val(load_val_i),
    .zero(zero_o), .snap(snap_o)
);

// File: tb/event_totalizer_tb.sv
module event_totalizer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 21;
    localparam logic [2:0] OP_GATE = 3'd0, OP_LOAD = 3'd1, OP_LATCH = 3'd2,
                           OP_PULSE = 3'd3, OP_WAIT = 3'd4, OP_BAD = 3'd5;

    // fields: op[37:35] arg[34:19] exp_snap[18:3] exp_zero[2] chk_snap[1] chk_zero[0]
    localparam logic [37:0] VEC [NV] = '{
        {OP_GATE,  16'd1,      16'd0, 1'b0, 2'b00},
        {OP_LOAD,  16'd10,     16'd0, 1'b0, 2'b00},
        {OP_LATCH, 16'd0,      16'd10, 1'b0, 2'b11},
        {OP_PULSE, 16'd1,      16'd0, 1'b0, 2'b00},
        {OP_LATCH, 16'd0,      16'd10, 1'b0, 2'b10},
        {OP_PULSE, 16'd3,      16'd0, 1'b0, 2'b00},
        {OP_LATCH, 16'd0,      16'd6, 1'b0, 2'b11},
        {OP_GATE,  16'd0,      16'd0, 1'b0, 2'b00},
        {OP_PULSE, 16'd4,      16'd0, 1'b0, 2'b00},
        {OP_LATCH, 16'd0,      16'd6, 1'b0, 2'b11},
        {OP_GATE,  16'd1,      16'd0, 1'b0, 2'b00},
        {OP_PULSE, 16'd4,      16'd0, 1'b0, 2'b00},
        {OP_LATCH, 16'd0,      16'd2, 1'b0, 2'b11},
        {OP_PULSE, 16'd1,      16'd0, 1'b0, 2'b01},
        {OP_PULSE, 16'd1,      16'd0, 1'b1, 2'b01},
        {OP_WAIT,  16'd20,     16'd0, 1'b1, 2'b01},
        {OP_PULSE, 16'd1,      16'd0, 1'b0, 2'b01},
        {OP_PULSE, 16'd1,      16'd0, 1'b0, 2'b00},
        {OP_LATCH, 16'd0,      16'd9, 1'b0, 2'b10},
        {OP_BAD,   16'h1234,   16'd0, 1'b0, 2'b00},
        {OP_LATCH, 16'd0,      16'd9, 1'b0, 2'b11}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_evt = 1'b0, ext_gate = 1'b0, src_int = 1'b0, slow_tb = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_code = 8'h00;
    logic [15:0] load_val = 16'd0;
    logic        zero;
    logic [15:0] snap;
    int          n_checks = 0, n_fails = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    event_totalizer u_dut (
        .clk(clk), .rst_n(rst_n), .ext_evt_i(ext_evt), .ext_gate_i(ext_gate),
        .src_int_i(src_int), .slow_tb_i(slow_tb), .cmd_valid_i(cmd_valid),
        .cmd_code_i(cmd_code), .load_val_i(load_val), .zero_o(zero), .snap_o(snap)
    );

    function automatic string req_of(int i);
        case (i)
            2, 20:         return "R1";
            14, 15:        return "R2";
            16, 18:        return "R3";
            6, 13:         return "R4";
            9:             return "R5";
            default:       return "R6";
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic command(logic [7:0] code);
        cmd_valid = 1'b1;
        cmd_code  = code;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_code  = 8'h00;
    endtask

    task automatic pulses(int n);
        for (int k = 0; k < n; k++) begin
            ext_evt = 1'b1; idle(2);
            ext_evt = 1'b0; idle(2);
        end
        idle(4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [15:0] a, b, c;
        idle(3);
        // R9: reset state
        check("R9", {31'd0, zero}, 32'd0);
        check("R9", {16'd0, snap}, 32'd0);
        rst_n = 1'b1;
        idle(2);
        command(8'h84);
        check("R9", {16'd0, snap}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [2:0]  op;
            logic [15:0] arg;
            op  = VEC[i][37:35];
            arg = VEC[i][34:19];
            case (op)
                OP_GATE:  begin ext_gate = arg[0]; idle(4); end
                OP_LOAD:  begin load_val = arg; command(8'h82); end
                OP_LATCH: command(8'h84);
                OP_PULSE: pulses(int'(arg));
                OP_WAIT:  idle(int'(arg));
                default:  begin load_val = arg; command(8'h83); idle(2); end
            endcase
            if (VEC[i][1]) check(req_of(i), {16'd0, snap}, {16'd0, VEC[i][18:3]});
            if (VEC[i][0]) check(req_of(i), {31'd0, zero}, {31'd0, VEC[i][2]});
        end

        // R7: internal fast timebase, enable low ignored
        load_val = 16'd1000;
        command(8'h82);
        ext_gate = 1'b0;
        src_int  = 1'b1;
        slow_tb  = 1'b0;
        idle(8);
        command(8'h84); a = snap;
        idle(39);
        command(8'h84); b = snap;
        check("R7", {16'd0, a - b}, 32'd10);

        // R7 / R8: slow timebase, readable value follows each tick
        slow_tb = 1'b1;
        idle(8);
        command(8'h84); a = snap;
        idle(799);
        command(8'h84); b = snap;
        check("R8", {16'd0, a - b}, 32'd2);

        // R10: back to external mode, count kept
        src_int = 1'b0;
        idle(4);
        command(8'h84); c = snap;
        idle(500);
        command(8'h84);
        check("R10", {16'd0, snap}, {16'd0, c});
        ext_gate = 1'b1;
        idle(4);
        pulses(4);
        command(8'h84);
        check("R10", {16'd0, snap}, {16'd0, c - 16'd4});

        // R9: reset in mid-run
        rst_n = 1'b0;
        idle(2);
        check("R9", {31'd0, zero}, 32'd0);
        check("R9", {16'd0, snap}, 32'd0);
        rst_n = 1'b1;
        idle(2);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule